// File: doc/BRIEF.md
# Shared Timer and Watchdog Prescaler

This block holds an 8-bit timer/counter, a watchdog counter and one prescaler counter. Only one of the two counters can use the prescaler at a time. A control word sets which counter owns the prescaler, the division ratio, the timer's clock source and which edge of the external pin counts.

The timer counts either every cycle of the instruction clock (`clk`) or edges on an external pin. Pin samples pass through a two-stage synchronizer before they count. When the timer wraps, it sets a sticky flag that software clears. The watchdog counts strobes from its own time base while it is enabled. When it wraps, it issues a one-cycle reset request.

Each counter has its own clear action, and each of them also resets the prescaler, but only while the prescaler belongs to that counter. A counter that does not own the prescaler counts its source directly.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: Control word layout with the default ratio-code width of 3 bits:
  - bits [2:0] hold the ratio code;
  - bit 3 is the owner bit (0 = timer owns the prescaler, 1 = watchdog owns it);
  - bit 4 is the edge select (0 = rising, 1 = falling);
  - bit 5 is the source select (0 = instruction clock, 1 = external pin).
- R2: While the timer owns the prescaler, ratio code k advances the timer once per 2^(k+1) source events: 2 for code 000, up to 256 for code 111.
- R3: While the watchdog owns the prescaler, ratio code k advances the watchdog once per 2^k time-base strobes: 1 for code 000, up to 128 for code 111.
- R4: The counter that does not own the prescaler advances once per source event of its own, with no division.
- R5: A timer write loads `tmrWrData` at that edge, with no increment on that edge. It also clears the prescaler, but only while the timer owns the prescaler.
- R6: `wdtClear` or `sleepCmd` zeroes the watchdog counter. Either one also clears the prescaler, but only while the watchdog owns the prescaler.
- R7: With the pin source selected, only the selected edge of `extPin` counts. A steady level or the other edge has no effect, and the instruction clock is ignored.
- R8: A pin change that is set up before clock edge k is seen by the timer at edge k+2. The timer still holds its old value after edge k+1.
- R9: When the timer wraps from all ones to zero, `tmrFlag` sets and stays set until `flagClear` is asserted with no overflow. An overflow wins over a clear in the same cycle.
- R10: While `wdtEnable` is 0, watchdog strobes are ignored: the watchdog count holds and no timeout is produced.
- R11: `wdtTimeout` is high for exactly the one cycle after the edge at which the watchdog counter wraps from all ones. A clear in the same cycle suppresses the timeout.
- R12: After reset, `tmrValue`, `tmrFlag` and `wdtTimeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWord | input | CODE_W+3 | Ratio code, owner bit, edge select, source select |
| extPin | input | 1 | External count pin (asynchronous) |
| tmrWrEn | input | 1 | Timer write strobe |
| tmrWrData | input | TMR_W | Value loaded into the timer |
| flagClear | input | 1 | Clears the overflow flag |
| wdtEnable | input | 1 | Watchdog run enable |
| wdtTick | input | 1 | Watchdog time-base strobe |
| wdtClear | input | 1 | Watchdog clear command |
| sleepCmd | input | 1 | Sleep command (clears the watchdog like `wdtClear`) |
| tmrValue | output | TMR_W | Current timer count |
| tmrFlag | output | 1 | Sticky timer overflow flag |
| wdtTimeout | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with PS_W=8 and TMR_W=8, so every timer ratio up to 1:256 is exercised at its true size. It sets WDT_W=4, so a watchdog wrap takes only 16 counter steps. This lets each watchdog ratio and each clear rule be checked at the exact strobe where the timeout must appear, and one strobe earlier where it must not. Odd strobe counts before a clear give the prescaler a state that exposes a missed or extra prescaler clear.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic psEvt;      // one event arrives at the prescaler
    logic psClr;      // clear the prescaler
    logic psToWdt;    // prescaler owner: 1 = watchdog
    logic tmrDirEvt;  // undivided timer event
    logic wdtDirEvt;  // undivided watchdog event
    logic tmrLoad;    // load timer from write data
    logic wdtClr;     // zero the watchdog
    logic flagClr;    // clear overflow flag
  } tpwStrobes_t;

endpackage

// File: rtl/tmr_wdt_ctrl.sv
module tmr_wdt_ctrl
  import tmr_wdt_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psToWdt,
  input  logic              edgeFall,
  input  logic              srcExt,
  input  logic              extPin,
  input  logic              tmrWrEn,
  input  logic              flagClear,
  input  logic              wdtEnable,
  input  logic              wdtTick,
  input  logic              wdtClear,
  input  logic              sleepCmd,
  output tpwStrobes_t       stb
);

  localparam int SYNC_D = 3;  // two sync stages plus one history stage

  logic [SYNC_D-1:0] pinQ;
  logic extEdge;
  logic srcEvt;
  logic wdtBase;
  logic wdtClrAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinQ <= '0;
    else       pinQ <= {pinQ[SYNC_D-2:0], extPin};
  end

  always_comb begin
    extEdge   = edgeFall ? (~pinQ[1] & pinQ[2]) : (pinQ[1] & ~pinQ[2]);
    srcEvt    = srcExt ? extEdge : 1'b1;
    wdtBase   = wdtTick & wdtEnable;
    wdtClrAny = wdtClear | sleepCmd;

    stb.psToWdt   = psToWdt;
    stb.psEvt     = psToWdt ? wdtBase : srcEvt;
    stb.tmrDirEvt = psToWdt ? srcEvt : 1'b0;
    stb.wdtDirEvt = psToWdt ? 1'b0 : wdtBase;
    stb.psClr     = psToWdt ? wdtClrAny : tmrWrEn;
    stb.tmrLoad   = tmrWrEn;
    stb.wdtClr    = wdtClrAny;
    stb.flagClr   = flagClear;
  end

endmodule

// File: rtl/tmr_wdt_dp.sv
module tmr_wdt_dp
  import tmr_wdt_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int TMR_W  = 8,
  parameter int WDT_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpwStrobes_t       stb,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic [TMR_W-1:0]  tmrWrData,
  output logic [TMR_W-1:0]  tmrValue,
  output logic              tmrFlag,
  output logic              wdtTimeout
);

  logic [PS_W-1:0]  psCnt;
  logic [PS_W-1:0]  wdtMask;
  logic [PS_W-1:0]  tmrMask;
  logic [PS_W-1:0]  selMask;
  logic             psTick;
  logic             tmrInc;
  logic             wdtInc;
  logic [WDT_W-1:0] wdtCnt;

  always_comb begin
    wdtMask = (PS_W'(1) << ratioCode) - PS_W'(1);
    tmrMask = (wdtMask << 1) | PS_W'(1);
    selMask = stb.psToWdt ? wdtMask : tmrMask;
    psTick  = stb.psEvt & ((psCnt & selMask) == selMask);
    tmrInc  = stb.tmrDirEvt | (psTick & ~stb.psToWdt);
    wdtInc  = stb.wdtDirEvt | (psTick & stb.psToWdt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          psCnt <= '0;
    else if (stb.psClr) psCnt <= '0;
    else if (stb.psEvt) psCnt <= psCnt + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrValue <= '0;
      tmrFlag  <= 1'b0;
    end else begin
      if (stb.tmrLoad)     tmrValue <= tmrWrData;
      else if (tmrInc)     tmrValue <= tmrValue + TMR_W'(1);
      if (!stb.tmrLoad && tmrInc && (&tmrValue)) tmrFlag <= 1'b1;
      else if (stb.flagClr)                      tmrFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtCnt     <= '0;
      wdtTimeout <= 1'b0;
    end else if (stb.wdtClr) begin
      wdtCnt     <= '0;
      wdtTimeout <= 1'b0;
    end else begin
      if (wdtInc) wdtCnt <= wdtCnt + WDT_W'(1);
      wdtTimeout <= wdtInc & (&wdtCnt);
    end
  end

endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler
  import tmr_wdt_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int TMR_W  = 8,
  parameter int WDT_W  = 8,
  parameter int CODE_W = $clog2(PS_W),
  parameter int CTRL_W = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              extPin,
  input  logic              tmrWrEn,
  input  logic [TMR_W-1:0]  tmrWrData,
  input  logic              flagClear,
  input  logic              wdtEnable,
  input  logic              wdtTick,
  input  logic              wdtClear,
  input  logic              sleepCmd,
  output logic [TMR_W-1:0]  tmrValue,
  output logic              tmrFlag,
  output logic              wdtTimeout
);

  tpwStrobes_t stb;

  tmr_wdt_ctrl #(.CODE_W(CODE_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .psToWdt  (ctrlWord[CODE_W]),
    .edgeFall (ctrlWord[CODE_W+1]),
    .srcExt   (ctrlWord[CODE_W+2]),
    .extPin   (extPin),
    .tmrWrEn  (tmrWrEn),
    .flagClear(flagClear),
    .wdtEnable(wdtEnable),
    .wdtTick  (wdtTick),
    .wdtClear (wdtClear),
    .sleepCmd (sleepCmd),
    .stb      (stb)
  );

  tmr_wdt_dp #(
    .PS_W(PS_W), .TMR_W(TMR_W), .WDT_W(WDT_W), .CODE_W(CODE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ratioCode (ctrlWord[CODE_W-1:0]),
    .tmrWrData (tmrWrData),
    .tmrValue  (tmrValue),
    .tmrFlag   (tmrFlag),
    .wdtTimeout(wdtTimeout)
  );

endmodule

// File: rtl/tmr_wdt_prescaler_chk.sv
module tmr_wdt_prescaler_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tmrWrEn,
  input logic [TMR_W-1:0] tmrWrData,
  input logic             flagClear,
  input logic             wdtEnable,
  input logic             wdtClear,
  input logic             sleepCmd,
  input logic [TMR_W-1:0] tmrValue,
  input logic             tmrFlag,
  input logic             wdtTimeout
);

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    tmrWrEn |=> tmrValue == $past(tmrWrData));

  assert_flag_at_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmrFlag) |-> tmrValue == '0);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tmrFlag && !flagClear) |=> tmrFlag);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEnable |=> !wdtTimeout);

  assert_clear_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wdtClear || sleepCmd) |=> !wdtTimeout);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout);

endmodule

bind tmr_wdt_prescaler tmr_wdt_prescaler_chk #(.TMR_W(TMR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .tmrWrEn   (tmrWrEn),
  .tmrWrData (tmrWrData),
  .flagClear (flagClear),
  .wdtEnable (wdtEnable),
  .wdtClear  (wdtClear),
  .sleepCmd  (sleepCmd),
  .tmrValue  (tmrValue),
  .tmrFlag   (tmrFlag),
  .wdtTimeout(wdtTimeout)
);

// File: tb/tb_tmr_wdt_prescaler.sv
module tb_tmr_wdt_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int PS_W   = 8;
  localparam int TMR_W  = 8;
  localparam int WDT_W  = 4;
  localparam int CODE_W = 3;
  localparam int CTRL_W = CODE_W + 3;

  // {ratio code[31:24], cycles[23:8], expected timer[7:0]}
  localparam logic [31:0] RATIO_VEC [8] = '{
    {8'd0, 16'd7,   8'd3},
    {8'd1, 16'd10,  8'd2},
    {8'd2, 16'd17,  8'd2},
    {8'd3, 16'd47,  8'd2},
    {8'd4, 16'd64,  8'd2},
    {8'd5, 16'd200, 8'd3},
    {8'd6, 16'd127, 8'd0},
    {8'd7, 16'd513, 8'd2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CTRL_W-1:0] ctrlWord = '0;
  logic              extPin = 1'b0;
  logic              tmrWrEn = 1'b0;
  logic [TMR_W-1:0]  tmrWrData = '0;
  logic              flagClear = 1'b0;
  logic              wdtEnable = 1'b1;
  logic              wdtTick = 1'b0;
  logic              wdtClear = 1'b0;
  logic              sleepCmd = 1'b0;
  logic [TMR_W-1:0]  tmrValue;
  logic              tmrFlag;
  logic              wdtTimeout;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  tmr_wdt_prescaler #(.PS_W(PS_W), .TMR_W(TMR_W), .WDT_W(WDT_W)) dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .extPin(extPin),
    .tmrWrEn(tmrWrEn), .tmrWrData(tmrWrData), .flagClear(flagClear),
    .wdtEnable(wdtEnable), .wdtTick(wdtTick), .wdtClear(wdtClear),
    .sleepCmd(sleepCmd), .tmrValue(tmrValue), .tmrFlag(tmrFlag),
    .wdtTimeout(wdtTimeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CTRL_W-1:0] mk(input bit src, input bit fall,
                                           input bit own, input int code);
    return {src, fall, own, CODE_W'(code)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrTmr(input int v);
    tmrWrEn = 1'b1; tmrWrData = TMR_W'(v);
    @(negedge clk);
    tmrWrEn = 1'b0;
  endtask

  task automatic wdtTicks(input int n);
    wdtTick = 1'b1;
    repeat (n) @(negedge clk);
    wdtTick = 1'b0;
  endtask

  task automatic pulseWdtClr();
    wdtClear = 1'b1; @(negedge clk); wdtClear = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R12 reset state
    check("R12 timer", tmrValue, 0);
    check("R12 flag", tmrFlag, 0);
    check("R12 timeout", wdtTimeout, 0);
    rstN = 1'b1;
    cyc(1);

    // R2 timer ratios, R1 owner bit 0
    foreach (RATIO_VEC[i]) begin
      ctrlWord = mk(0, 0, 0, int'(RATIO_VEC[i][31:24]));
      wrTmr(0);
      cyc(int'(RATIO_VEC[i][23:8]));
      check("R2 ratio", tmrValue, int'(RATIO_VEC[i][7:0]));
    end

    // R4 timer direct while watchdog owns prescaler
    ctrlWord = mk(0, 0, 1, 5);
    wrTmr(0); cyc(5);
    check("R4 timer direct", tmrValue, 5);

    // R3 watchdog ratio 1:1 and 1:2 (WDT_W=4 -> 16 steps)
    ctrlWord = mk(0, 0, 1, 0);
    pulseWdtClr();
    wdtTicks(15); check("R3 code0 early", wdtTimeout, 0);
    wdtTicks(1);  check("R3 code0 timeout", wdtTimeout, 1);
    cyc(1);       check("R11 pulse width", wdtTimeout, 0);
    ctrlWord = mk(0, 0, 1, 1);
    pulseWdtClr();
    wdtTicks(31); check("R3 code1 early", wdtTimeout, 0);
    wdtTicks(1);  check("R3 code1 timeout", wdtTimeout, 1);

    // R5 timer write does not clear prescaler owned by watchdog
    pulseWdtClr();
    wdtTicks(1);
    wrTmr(9);
    check("R5 load", tmrValue, 9);
    wdtTicks(31); check("R5 no ps clear when wdt owns", wdtTimeout, 1);

    // R6 sleep clears watchdog and owned prescaler
    pulseWdtClr();
    wdtTicks(21);
    sleepCmd = 1'b1; @(negedge clk); sleepCmd = 1'b0;
    wdtTicks(31); check("R6 sleep clear early", wdtTimeout, 0);
    wdtTicks(1);  check("R6 sleep clear timeout", wdtTimeout, 1);

    // R5 timer write clears prescaler owned by timer
    ctrlWord = mk(0, 0, 0, 1);
    wrTmr(0); cyc(2);
    wrTmr(5); cyc(3);
    check("R5 ps cleared", tmrValue, 5);
    cyc(1);
    check("R5 ps cleared next", tmrValue, 6);

    // R6 watchdog clear leaves timer-owned prescaler alone
    wrTmr(0); cyc(2);
    pulseWdtClr();
    cyc(5);
    check("R6 no ps clear when timer owns", tmrValue, 2);

    // R4 watchdog direct while timer owns prescaler, R10 enable gating
    ctrlWord = mk(0, 0, 0, 3);
    pulseWdtClr();
    wdtTicks(15); check("R4 wdt direct early", wdtTimeout, 0);
    wdtTicks(1);  check("R4 wdt direct timeout", wdtTimeout, 1);
    pulseWdtClr();
    wdtEnable = 1'b0;
    wdtTicks(40); check("R10 disabled", wdtTimeout, 0);
    wdtEnable = 1'b1;
    wdtTicks(15); check("R10 count held", wdtTimeout, 0);
    wdtTicks(1);  check("R10 resume timeout", wdtTimeout, 1);

    // R7 / R8 external pin, rising edge, undivided
    ctrlWord = mk(1, 0, 1, 0);
    wrTmr(0); cyc(4);
    check("R7 clock ignored", tmrValue, 0);
    extPin = 1'b1;
    cyc(1); cyc(1);
    check("R8 not yet at k+1", tmrValue, 0);
    cyc(1);
    check("R8 counted at k+2", tmrValue, 1);
    cyc(5);
    check("R7 level ignored", tmrValue, 1);
    ctrlWord = mk(1, 1, 1, 0);
    cyc(3);
    check("R7 select change", tmrValue, 1);
    extPin = 1'b0; cyc(3);
    check("R7 falling edge", tmrValue, 2);
    extPin = 1'b1; cyc(4);
    check("R7 rising ignored", tmrValue, 2);

    // R9 overflow flag
    ctrlWord = mk(0, 0, 1, 0);
    wrTmr(253); cyc(2);
    check("R9 before wrap value", tmrValue, 255);
    check("R9 before wrap flag", tmrFlag, 0);
    cyc(1);
    check("R9 wrap value", tmrValue, 0);
    check("R9 wrap flag", tmrFlag, 1);
    cyc(4);
    check("R9 sticky", tmrFlag, 1);
    flagClear = 1'b1; @(negedge clk); flagClear = 1'b0;
    check("R9 cleared", tmrFlag, 0);
    wrTmr(255);
    flagClear = 1'b1; @(negedge clk); flagClear = 1'b0;
    check("R9 set wins", tmrFlag, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule